// File: doc/BRIEF.md
# Self-Centering Elastic Bit FIFO

This block is a one-bit-wide elastic store that sits on a serial stream and absorbs the phase wander between a write bit strobe and a read bit strobe. Both strobes are clock enables in a single clock domain. Each write strobe stores one bit. Each read strobe presents the oldest stored bit on `rd_bit`. The block reports its occupancy, raises empty and full indications, and records overrun and underrun events in sticky flags. Each of the two sticky flags can be enabled to pull an active-low interrupt.

An optional self-centering mode makes the store recover by itself after a slip. Enabling it opens a timed window that is counted in read bit periods. Inside the window, any read that finds the occupancy too close to either end moves the read pointer to sit half the depth behind the write pointer. The bits skipped or repeated by that move are lost. Any overrun or underrun re-opens the window. Read periods during which the store is empty or full are not counted, so the window stretches for as long as such an alarm lasts.

With centering disabled the pointers are never moved. Bits then pass through in order, and a slip only drops a write or repeats the last output bit.

Top module: `elastic_bit_fifo`

## Requirements
- R1: After synchronous reset the block shows level 0, `empty`=1, `full`=0, `rd_bit`=0, both sticky flags 0, `irq_n`=1, `center_on`=0 and `window_open`=0. Centering and both interrupt enables start off.
- R2: Bits come out on `rd_bit` in the order they were written. `level` rises by one for each lone write and falls by one for each lone read. `empty` is 1 exactly at level 0, and `full` is 1 exactly at level DEPTH (default 32).
- R3: Simultaneous write and read strobes leave `level` unchanged. If the store is empty at that time, the bit being written appears on `rd_bit`.
- R4: A lone read while empty is an underrun. It sets `und_flag`, leaves `rd_bit` at its previous value and, with no window open, leaves `level` at 0.
- R5: A lone write while full is an overrun. It sets `ovr_flag` and the written bit is discarded, so `level` stays at DEPTH.
- R6: The sticky flags stay set until a `flag_clr` pulse. A new event in the same cycle as `flag_clr` keeps its flag set.
- R7: `irq_n` is 0 exactly when (`ovr_flag` and the overrun enable) or (`und_flag` and the underrun enable) holds.
- R8: A configuration write (`cfg_we`=1) turns centering on only when `cfg_center`=1 and `cfg_sync`=0 in the same write. Any other configuration write turns centering off and closes the window.
- R9: Turning centering on opens the window (`window_open`=1) for WINDOW (default 384) counted read strobes. The window closes on the edge of the last counted strobe.
- R10: A read strobe does not count toward the window if, in that cycle, the store is empty or full.
- R11: While centering is on, an overrun or underrun reloads the window to a full WINDOW counted read strobes.
- R12: While the window is open, a read strobe that finds the level below GUARD (default 4) or above DEPTH-GUARD re-centers the store. After that edge `level` equals DEPTH/2.
- R13: While no window is open, `level` changes by at most one per cycle and no pointer is repositioned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write bit strobe |
| wr_bit | input | 1 | Bit to store |
| rd_stb | input | 1 | Read bit strobe |
| rd_bit | output | 1 | Registered output bit |
| cfg_we | input | 1 | Configuration write pulse |
| cfg_center | input | 1 | Requested centering enable |
| cfg_sync | input | 1 | Sync mode; 1 blocks centering |
| cfg_ovr_ie | input | 1 | Overrun interrupt enable |
| cfg_und_ie | input | 1 | Underrun interrupt enable |
| flag_clr | input | 1 | Clears both sticky flags |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level is DEPTH |
| level | output | $clog2(DEPTH+1) | Current occupancy |
| ovr_flag | output | 1 | Sticky overrun |
| und_flag | output | 1 | Sticky underrun |
| irq_n | output | 1 | Active-low interrupt |
| center_on | output | 1 | Centering enable as held |
| window_open | output | 1 | Centering window running |

## Verification
Every result of a strobe, a configuration write or a clear becomes visible at the first rising edge after it is applied: `rd_bit`, `level`, `empty`, `full`, both flags, `irq_n`, `center_on` and `window_open`. None of these results is due later than that. The bench applies inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It compares every output against a model stepped once per cycle from the requirements. The window-length checks count strobes explicitly, so the exact closing edge is checked. The checks include the stretched window case and the reloaded window case.

// File: rtl/ebf_pkg.sv
package ebf_pkg;
  typedef struct packed {
    logic center;
    logic ovr_ie;
    logic und_ie;
  } ebf_cfg_t;
endpackage

// File: rtl/ebf_store.sv
// Bit storage: one write port, one registered read port with read-first
// behaviour, laid out so that block RAM can be inferred.
module ebf_store #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic          wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  input  logic          byp,
  output logic          q
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // An empty store either forwards the incoming bit or keeps the last one.
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else if (re) begin
      if (!byp)    q <= mem[ra];
      else if (we) q <= wd;
    end
  end
endmodule

// File: rtl/ebf_ptrs.sv
// Pointer and occupancy control, slip detection and re-centering.
module ebf_ptrs #(
  parameter int DEPTH = 32,
  parameter int GUARD = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          win_open,
  output logic          we,
  output logic [AW-1:0] wa,
  output logic          re,
  output logic [AW-1:0] ra,
  output logic          byp,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          alarm,
  output logic          ovr_evt,
  output logic          und_evt
);
  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          empty_q, full_q;
  logic          at_empty, at_full, near_edge, recenter, w_acc, r_acc;

  always_comb begin
    at_empty  = (cnt_q == '0);
    at_full   = (cnt_q == CW'(DEPTH));
    ovr_evt   = wr_stb & ~rd_stb & at_full;
    und_evt   = rd_stb & ~wr_stb & at_empty;
    near_edge = (cnt_q < CW'(GUARD)) | (cnt_q > CW'(DEPTH - GUARD));
    recenter  = win_open & rd_stb & near_edge;
    w_acc     = wr_stb & ~ovr_evt;
    r_acc     = rd_stb & ~und_evt;
    wp_n      = wp_q + AW'(w_acc);
    if (recenter) begin
      rp_n  = wp_n - AW'(HALF);
      cnt_n = CW'(HALF);
    end else begin
      rp_n  = rp_q + AW'(r_acc);
      cnt_n = cnt_q + CW'(w_acc) - CW'(r_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      wp_q    <= wp_n;
      rp_q    <= rp_n;
      cnt_q   <= cnt_n;
      empty_q <= (cnt_n == '0);
      full_q  <= (cnt_n == CW'(DEPTH));
    end
  end

  assign we    = w_acc;
  assign wa    = wp_q;
  assign re    = rd_stb;
  assign ra    = rp_q;
  assign byp   = at_empty;
  assign level = cnt_q;
  assign empty = empty_q;
  assign full  = full_q;
  assign alarm = at_empty | at_full;

  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(empty_q && full_q));
  p_simul_level_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && rd_stb && !win_open) |=> cnt_q == $past(cnt_q));
  p_overrun_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ovr_evt && !win_open) |=> full_q);
  p_recenter_half_r12: assert property (@(posedge clk) disable iff (rst)
    (win_open && rd_stb && near_edge) |=> cnt_q == CW'(HALF));
  p_no_jump_r13: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1 ||
                   cnt_q + 1 == $past(cnt_q)));
endmodule

// File: rtl/ebf_window.sv
// Configuration hold and the centering window counter.
module ebf_window
  import ebf_pkg::*;
#(
  parameter int WINDOW = 384,
  localparam int WW = $clog2(WINDOW + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_we,
  input  logic     cfg_center,
  input  logic     cfg_sync,
  input  logic     cfg_ovr_ie,
  input  logic     cfg_und_ie,
  input  logic     ovr_evt,
  input  logic     und_evt,
  input  logic     rd_stb,
  input  logic     alarm,
  output ebf_cfg_t cfg,
  output logic     win_open
);
  ebf_cfg_t      cfg_q;
  logic [WW-1:0] wcnt_q;
  logic          arm, slip_rearm;

  assign arm        = cfg_we & cfg_center & ~cfg_sync;
  assign slip_rearm = cfg_q.center & (ovr_evt | und_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{center: 1'b0, ovr_ie: 1'b0, und_ie: 1'b0};
    end else if (cfg_we) begin
      cfg_q <= '{center: arm, ovr_ie: cfg_ovr_ie, und_ie: cfg_und_ie};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  wcnt_q <= '0;
    else if (cfg_we && !arm)                  wcnt_q <= '0;
    else if (arm || slip_rearm)               wcnt_q <= WW'(WINDOW);
    else if (wcnt_q != '0 && rd_stb && !alarm) wcnt_q <= wcnt_q - 1'b1;
  end

  assign cfg      = cfg_q;
  assign win_open = (wcnt_q != '0);

  p_sync_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sync) |=> !cfg_q.center && wcnt_q == '0);
  p_window_needs_center_r8: assert property (@(posedge clk) disable iff (rst)
    (wcnt_q != '0) |-> cfg_q.center);
  p_alarm_stretch_r10: assert property (@(posedge clk) disable iff (rst)
    (wcnt_q != '0 && alarm && !cfg_we) |=> wcnt_q >= $past(wcnt_q));
  p_slip_reload_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.center && (ovr_evt || und_evt) && !cfg_we) |=> wcnt_q == WW'(WINDOW));
endmodule

// File: rtl/ebf_irq.sv
// Sticky slip flags and the active-low interrupt.
module ebf_irq (
  input  logic clk,
  input  logic rst,
  input  logic ovr_evt,
  input  logic und_evt,
  input  logic flag_clr,
  input  logic ovr_ie,
  input  logic und_ie,
  output logic ovr_flag,
  output logic und_flag,
  output logic irq_n
);
  logic ovr_q, und_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      ovr_q <= ovr_evt | (ovr_q & ~flag_clr);
      und_q <= und_evt | (und_q & ~flag_clr);
    end
  end

  assign ovr_flag = ovr_q;
  assign und_flag = und_q;
  assign irq_n    = ~((ovr_q & ovr_ie) | (und_q & und_ie));

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> ovr_q);
  p_und_set_r4: assert property (@(posedge clk) disable iff (rst)
    und_evt |=> und_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !ovr_evt && !und_evt) |=> !ovr_q && !und_q);
endmodule

// File: rtl/elastic_bit_fifo.sv
module elastic_bit_fifo
  import ebf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int GUARD  = 4,
  parameter int WINDOW = 384,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          wr_bit,
  input  logic          rd_stb,
  output logic          rd_bit,
  input  logic          cfg_we,
  input  logic          cfg_center,
  input  logic          cfg_sync,
  input  logic          cfg_ovr_ie,
  input  logic          cfg_und_ie,
  input  logic          flag_clr,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level,
  output logic          ovr_flag,
  output logic          und_flag,
  output logic          irq_n,
  output logic          center_on,
  output logic          window_open
);
  logic          we, re, byp, alarm, ovr_evt, und_evt, win_open;
  logic [AW-1:0] wa, ra;
  ebf_cfg_t      cfg;

  initial begin
    a_depth_pow2: assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH >= 4 * GUARD);
  end

  ebf_ptrs #(.DEPTH(DEPTH), .GUARD(GUARD)) u_ptrs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .win_open(win_open), .we(we), .wa(wa), .re(re), .ra(ra), .byp(byp),
    .level(level), .empty(empty), .full(full), .alarm(alarm),
    .ovr_evt(ovr_evt), .und_evt(und_evt)
  );

  ebf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(we), .wa(wa), .wd(wr_bit),
    .re(re), .ra(ra), .byp(byp), .q(rd_bit)
  );

  ebf_window #(.WINDOW(WINDOW)) u_window (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_center(cfg_center),
    .cfg_sync(cfg_sync), .cfg_ovr_ie(cfg_ovr_ie), .cfg_und_ie(cfg_und_ie),
    .ovr_evt(ovr_evt), .und_evt(und_evt), .rd_stb(rd_stb), .alarm(alarm),
    .cfg(cfg), .win_open(win_open)
  );

  ebf_irq u_irq (
    .clk(clk), .rst(rst), .ovr_evt(ovr_evt), .und_evt(und_evt),
    .flag_clr(flag_clr), .ovr_ie(cfg.ovr_ie), .und_ie(cfg.und_ie),
    .ovr_flag(ovr_flag), .und_flag(und_flag), .irq_n(irq_n)
  );

  assign center_on   = cfg.center;
  assign window_open = win_open;
endmodule

// File: tb/tb_elastic_bit_fifo.sv
`timescale 1ns/1ps
module tb_elastic_bit_fifo;
  localparam int DEPTH = 32, GUARD = 4, WINDOW = 384, HALF = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, wr_stb, wr_bit, rd_stb, rd_bit, cfg_we, cfg_center, cfg_sync;
  logic cfg_ovr_ie, cfg_und_ie, flag_clr, empty, full, ovr_flag, und_flag;
  logic irq_n, center_on, window_open;
  logic [5:0] level;

  elastic_bit_fifo dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_stb(rd_stb),
    .rd_bit(rd_bit), .cfg_we(cfg_we), .cfg_center(cfg_center),
    .cfg_sync(cfg_sync), .cfg_ovr_ie(cfg_ovr_ie), .cfg_und_ie(cfg_und_ie),
    .flag_clr(flag_clr), .empty(empty), .full(full), .level(level),
    .ovr_flag(ovr_flag), .und_flag(und_flag), .irq_n(irq_n),
    .center_on(center_on), .window_open(window_open)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Model state, stepped from the requirements.
  int m_wp, m_rp, m_cnt, m_wcnt;
  bit m_mem [DEPTH];
  bit m_val [DEPTH];
  bit m_dout, m_dval, m_center, m_oie, m_uie, m_of, m_uf;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wp = 0; m_rp = 0; m_cnt = 0; m_wcnt = 0;
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = 0; m_val[i] = 0; end
    m_dout = 0; m_dval = 1; m_center = 0; m_oie = 0; m_uie = 0; m_of = 0; m_uf = 0;
  endtask

  task automatic model_step(input bit w, wb, r, cw, cc, cs, co, cu, clr);
    bit ovr, und, alarm_now, rec, wacc, racc, arm, old_center;
    ovr = w && !r && m_cnt == DEPTH;
    und = r && !w && m_cnt == 0;
    alarm_now = (m_cnt == 0) || (m_cnt == DEPTH);
    rec = (m_wcnt != 0) && r && (m_cnt < GUARD || m_cnt > DEPTH - GUARD);
    wacc = w && !ovr;
    racc = r && !und;
    if (r) begin
      if (m_cnt == 0) begin
        if (w) begin m_dout = wb; m_dval = 1; end
      end else begin
        m_dout = m_mem[m_rp]; m_dval = m_val[m_rp];
      end
    end
    if (wacc) begin m_mem[m_wp] = wb; m_val[m_wp] = 1; m_wp = (m_wp + 1) % DEPTH; end
    if (rec) begin
      m_rp = (m_wp - HALF + DEPTH) % DEPTH; m_cnt = HALF;
    end else begin
      if (racc) m_rp = (m_rp + 1) % DEPTH;
      m_cnt = m_cnt + int'(wacc) - int'(racc);
    end
    old_center = m_center;
    arm = cw && cc && !cs;
    if (cw) begin m_center = arm; m_oie = co; m_uie = cu; end
    if (cw && !arm) m_wcnt = 0;
    else if (arm || (old_center && (ovr || und))) m_wcnt = WINDOW;
    else if (m_wcnt != 0 && r && !alarm_now) m_wcnt--;
    m_of = ovr || (m_of && !clr);
    m_uf = und || (m_uf && !clr);
  endtask

  task automatic compare_model();
    chk(level == m_cnt, "R2", "level", level, m_cnt);
    chk(empty == (m_cnt == 0), "R2", "empty", empty, m_cnt == 0);
    chk(full == (m_cnt == DEPTH), "R2", "full", full, m_cnt == DEPTH);
    if (m_dval) chk(rd_bit == m_dout, "R2", "rd_bit", rd_bit, m_dout);
    chk(ovr_flag == m_of, "R6", "ovr_flag", ovr_flag, m_of);
    chk(und_flag == m_uf, "R6", "und_flag", und_flag, m_uf);
    chk(irq_n == !((m_of && m_oie) || (m_uf && m_uie)), "R7", "irq_n", irq_n,
        !((m_of && m_oie) || (m_uf && m_uie)));
    chk(center_on == m_center, "R8", "center_on", center_on, m_center);
    chk(window_open == (m_wcnt != 0), "R9", "window_open", window_open, m_wcnt != 0);
  endtask

  // Inputs are driven at the falling edge; results are sampled one edge later.
  task automatic tick(input bit w, wb, r, cw, cc, cs, co, cu, clr);
    wr_stb = w; wr_bit = wb; rd_stb = r; cfg_we = cw; cfg_center = cc;
    cfg_sync = cs; cfg_ovr_ie = co; cfg_und_ie = cu; flag_clr = clr;
    model_step(w, wb, r, cw, cc, cs, co, cu, clr);
    @(posedge clk);
    @(negedge clk);
    compare_model();
    wr_stb = 0; rd_stb = 0; cfg_we = 0; flag_clr = 0;
  endtask

  task automatic do_w(input bit b);  tick(1, b, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_r();             tick(0, 0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_rw(input bit b); tick(1, b, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_cfg(input bit c, s, o, u); tick(0, 0, 0, 1, c, s, o, u, 0); endtask
  task automatic do_clr();           tick(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit pat [20];
    void'($urandom(32'd2024));
    rst = 1; wr_stb = 0; wr_bit = 0; rd_stb = 0; cfg_we = 0; cfg_center = 0;
    cfg_sync = 1; cfg_ovr_ie = 0; cfg_und_ie = 0; flag_clr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(level == 0 && empty && !full && !rd_bit, "R1", "level/empty/full/rd_bit", level, 0);
    chk(!ovr_flag && !und_flag && irq_n, "R1", "flags/irq_n", irq_n, 1);
    chk(!center_on && !window_open, "R1", "center/window", center_on, 0);

    // R2 order preserved
    for (int i = 0; i < 20; i++) begin pat[i] = 1'($urandom); do_w(pat[i]); end
    chk(level == 20, "R2", "level after 20 writes", level, 20);
    for (int i = 0; i < 20; i++) begin
      do_r();
      chk(rd_bit == pat[i], "R2", "order", rd_bit, pat[i]);
    end
    chk(empty, "R2", "empty after drain", empty, 1);

    // R3 bypass at empty and level unchanged
    do_rw(1);
    chk(rd_bit == 1 && level == 0, "R3", "bypass 1", rd_bit, 1);
    do_rw(0);
    chk(rd_bit == 0 && level == 0, "R3", "bypass 0", rd_bit, 0);
    do_w(1);
    do_rw(0);
    chk(level == 1 && rd_bit == 1, "R3", "simul level", level, 1);

    // R4 underrun keeps last bit
    do_r();
    do_r();
    chk(und_flag && rd_bit == 0 && level == 0, "R4", "underrun", und_flag, 1);
    chk(irq_n, "R7", "irq masked", irq_n, 1);
    do_cfg(0, 1, 0, 1);
    chk(!irq_n, "R7", "und irq enabled", irq_n, 0);

    // R6 clear, and set winning over clear
    do_clr();
    chk(!und_flag && irq_n, "R6", "clear", und_flag, 0);
    tick(0, 0, 1, 0, 0, 0, 0, 0, 1);
    chk(und_flag, "R6", "set beats clear", und_flag, 1);
    do_clr();

    // R5 overrun at full
    for (int i = 0; i < DEPTH; i++) do_w(1'(i));
    chk(full && level == DEPTH, "R5", "full", level, DEPTH);
    do_w(1);
    chk(ovr_flag && level == DEPTH, "R5", "overrun level", level, DEPTH);
    chk(irq_n, "R7", "ovr masked", irq_n, 1);
    do_cfg(0, 1, 1, 0);
    chk(!irq_n, "R7", "ovr irq", irq_n, 0);
    do_r();
    chk(rd_bit == 0, "R5", "oldest bit kept", rd_bit, 0);
    do_clr();

    // R13 pointers never jump with no window: drain to low levels
    for (int i = 0; i < DEPTH - 2; i++) do_r();
    do_r();
    chk(level == 0, "R13", "no recenter", level, 0);

    // R8 sync blocks centering
    do_cfg(1, 1, 0, 0);
    chk(!center_on && !window_open, "R8", "sync=1 blocks", center_on, 0);
    do_cfg(1, 0, 0, 0);
    chk(center_on && window_open, "R8", "sync=0 arms", center_on, 1);
    do_cfg(0, 0, 0, 0);
    chk(!center_on && !window_open, "R8", "disarm", window_open, 0);

    // R9 window length with level at half
    for (int i = 0; i < HALF; i++) do_w(1'(i));
    do_cfg(1, 0, 0, 0);
    for (int i = 0; i < WINDOW - 1; i++) do_rw(1'($urandom));
    chk(window_open && level == HALF, "R9", "open after W-1", window_open, 1);
    do_rw(0);
    chk(!window_open, "R9", "closed after W", window_open, 0);

    // R10/R12: empty alarm stretches window, recenter to half
    do_cfg(0, 0, 0, 0);
    for (int i = 0; i < HALF; i++) do_r();
    chk(level == 0, "R10", "drained", level, 0);
    do_cfg(1, 0, 0, 0);
    do_rw(1);
    chk(level == HALF && rd_bit == 1, "R12", "recenter from empty", level, HALF);
    for (int i = 0; i < WINDOW - 1; i++) do_rw(1'($urandom));
    chk(window_open, "R10", "stretched still open", window_open, 1);
    do_rw(0);
    chk(!window_open, "R10", "stretched closed", window_open, 0);

    // R11: overrun with centering on reloads window
    for (int i = 0; i < HALF; i++) do_w(1);
    chk(full && !window_open, "R11", "full, closed", window_open, 0);
    do_w(0);
    chk(window_open && ovr_flag && level == DEPTH, "R11", "reload", window_open, 1);
    do_rw(1);
    chk(level == HALF, "R12", "recenter from full", level, HALF);
    for (int i = 0; i < WINDOW - 1; i++) do_rw(1'($urandom));
    chk(window_open, "R11", "open after W-1 counted", window_open, 1);
    do_rw(0);
    chk(!window_open, "R11", "closed after W counted", window_open, 0);
    // R12 guard: lone reads from half recenter once below GUARD
    do_cfg(1, 0, 0, 0);
    for (int i = 0; i < HALF - GUARD + 1; i++) do_r();
    chk(level == GUARD - 1, "R12", "below guard", level, GUARD - 1);
    do_r();
    chk(level == HALF, "R12", "guard recenter", level, HALF);

    // Random: centering off then on, with occasional clears and reconfigs
    do_cfg(0, 0, 1, 1);
    for (int i = 0; i < 4000; i++)
      tick(($urandom % 100) < 50, 1'($urandom), ($urandom % 100) < 50,
           0, 0, 0, 0, 0, ($urandom % 50) == 0);
    do_cfg(1, 0, 1, 1);
    for (int i = 0; i < 4000; i++) begin
      bit cw = ($urandom % 400) == 0;
      tick(($urandom % 100) < 52, 1'($urandom), ($urandom % 100) < 48,
           cw, cw ? 1'b1 : 1'b0, cw ? 1'($urandom) : 1'b0, 1'($urandom), 1'($urandom),
           ($urandom % 60) == 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule